// File: doc/BRIEF.md
# Receive Ring Buffer Manager

This block places received frames into a circular buffer held in local byte-addressed memory. The memory is divided into 256-byte pages. A byte address is the page number shifted left by eight, plus the offset inside the page. The ring covers the pages from a first-page register up to, but not including, a limit-page register. A write-page register names the page where the next frame will begin. A fence-page register is owned by the host and marks the oldest page it has not yet read.

Frames arrive one byte per cycle on a valid/data/end stream. The status byte is presented together with the final byte. Payload bytes go in after a 4-byte gap at the frame's starting page, and storage wraps from the last ring page back to the first. Once the final byte is in, the manager decides what to do with the frame:

- **Keep it.** The header is written into the gap, and then the write page moves to the next free page.
- **Drop it silently.** This applies to a frame that ended with an error and is not being saved. The write page is left where it was, so the frame's space is reused.
- **Report it as missed.** This applies in monitor mode, when a write would land in the fence page, or while the overwrite flag is set.

A write that would land in the fence page sets a sticky overwrite flag. That flag stays set until the host moves the fence.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset the register port reads first page 0x40, limit page 0x80, write page 0x41, fence page 0x40, mode 0 and status 0, and memWe is low.
- R2: Payload byte i of a frame that starts on page S is written to byte address S*256 + 4 + i. When a page fills, storage continues at offset 0 of the following ring page.
- R3: The ring page after limit-1 is the first page. This applies both to payload storage and to the next-frame page.
- R4: A kept frame gets a header at offsets 0..3 of its starting page, in this order: the status byte, the next-frame page, the low byte of the count, and the high byte of the count. The count is the payload length plus 4.
- R5: The header is written after the last payload byte, one byte per cycle. frmStored pulses in the cycle of the final header byte. The write page then becomes the page that holds the first unwritten address, rounded up to a whole page.
- R6: When a frame's status bit 0 is 0 (error) and mode bit 0 (keep bad frames) is clear, no header is written, neither pulse fires, and the write page is unchanged.
- R7: When mode bit 0 is set, a frame with status bit 0 equal to 0 is kept exactly like a good frame.
- R8: When mode bit 1 (monitor) is set, a frame causes no memory writes and frmMissed pulses once. The write page is unchanged.
- R9: No byte is ever written to the fence page. The first byte aimed at it sets ovwFlag (also status bit 0 at address 5). That byte and every later byte of the frame are dropped, the frame is reported missed, and the write page is unchanged.
- R10: While ovwFlag is set, every frame is reported missed and causes no memory writes.
- R11: ovwFlag clears only when the host writes the fence register with a value different from its current one. Rewriting the same value leaves the flag set.
- R12: Register addresses: 0 first page, 1 limit page, 2 write page, 3 fence page, 4 mode, 5 status (read only). Each writable register reads back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational) |
| frmValid | input | 1 | Frame byte valid |
| frmData | input | 8 | Frame byte |
| frmEnd | input | 1 | Marks the last byte of a frame |
| frmStatus | input | 8 | Receive status; sampled with the last byte; bit 0 = good |
| memWe | output | 1 | Buffer memory write enable |
| memAddr | output | 16 | Buffer memory byte address |
| memData | output | 8 | Buffer memory write data |
| frmStored | output | 1 | Pulse: frame kept and header written |
| frmMissed | output | 1 | Pulse: frame reported missed |
| ovwFlag | output | 1 | Sticky ring overwrite flag |

## Verification
The hardest case to reach is an overrun that begins partway through a frame, exactly at a page crossing. The bench shrinks the ring to three pages and places the write page just before the wrap. It sets the fence on the first ring page, so a 300-byte frame fills one page and then runs into the fence. It then counts every write that lands on the fence page (zero are expected) and every write in total (exactly the 252 that fit). An overrun at the very start of a frame is reached by setting the fence equal to the write page. The flag's clearing rule is tested by rewriting the same fence value before writing a new one.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] ADDR_FIRST  = 3'd0;
  localparam logic [REG_AW-1:0] ADDR_LIMIT  = 3'd1;
  localparam logic [REG_AW-1:0] ADDR_WRPAGE = 3'd2;
  localparam logic [REG_AW-1:0] ADDR_FENCE  = 3'd3;
  localparam logic [REG_AW-1:0] ADDR_MODE   = 3'd4;
  localparam logic [REG_AW-1:0] ADDR_STAT   = 3'd5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RECV = 2'd1,
    ST_HDR  = 2'd2
  } ringState_t;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic       beginFrame;
    logic       takeByte;
    logic       doWrite;
    logic       markOverrun;
    logic       markMissed;
    logic       endByte;
    logic       hdrWrite;
    logic [1:0] hdrIdx;
    logic       commit;
  } ringStrobe_t;
endpackage

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
  import rx_ring_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frmValid,
  input  logic        frmEnd,
  input  logic        frmGood,
  input  logic        modeMonitor,
  input  logic        modeKeepBad,
  input  logic        ovwSet,
  input  logic        curIsFence,
  input  logic        ptrIsFence,
  output ringStrobe_t stb
);
  ringState_t state, stateNext;
  logic       frameBlocked;
  logic [1:0] hdrCnt;

  logic byteIn, targetIsFence, alreadyBlocked, blockedNow, endNow, toHdr;

  always_comb begin
    byteIn         = frmValid && (state != ST_HDR);
    targetIsFence  = (state == ST_IDLE) ? curIsFence : ptrIsFence;
    alreadyBlocked = (state == ST_RECV) && frameBlocked;
    blockedNow     = modeMonitor || ovwSet || alreadyBlocked || targetIsFence;
    endNow         = byteIn && frmEnd;
    toHdr          = endNow && !blockedNow && (frmGood || modeKeepBad);

    stb             = '0;
    stb.beginFrame  = byteIn && (state == ST_IDLE);
    stb.takeByte    = byteIn;
    stb.doWrite     = byteIn && !blockedNow;
    stb.markOverrun = byteIn && !modeMonitor && !ovwSet && !alreadyBlocked && targetIsFence;
    stb.markMissed  = endNow && blockedNow;
    stb.endByte     = endNow;
    stb.hdrWrite    = (state == ST_HDR);
    stb.hdrIdx      = hdrCnt;
    stb.commit      = (state == ST_HDR) && (hdrCnt == 2'd3);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (byteIn) stateNext = endNow ? (toHdr ? ST_HDR : ST_IDLE) : ST_RECV;
      ST_RECV: if (endNow) stateNext = toHdr ? ST_HDR : ST_IDLE;
      ST_HDR:  if (hdrCnt == 2'd3) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      frameBlocked <= 1'b0;
      hdrCnt       <= '0;
    end else begin
      state <= stateNext;
      if (byteIn) frameBlocked <= blockedNow;
      hdrCnt <= (state == ST_HDR) ? hdrCnt + 2'd1 : 2'd0;
    end
  end

  // R5
  hdr_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HDR && $past(state) != ST_HDR) |-> $past(frmValid && frmEnd));
endmodule

// File: rtl/rx_ring_dp.sv
module rx_ring_dp
  import rx_ring_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int OFF_W     = 8,
  parameter int HDR_LEN   = 4,
  parameter logic [PAGE_W-1:0] RST_FIRST  = 8'h40,
  parameter logic [PAGE_W-1:0] RST_LIMIT  = 8'h80,
  parameter logic [PAGE_W-1:0] RST_WRPAGE = 8'h41,
  parameter logic [PAGE_W-1:0] RST_FENCE  = 8'h40
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ringStrobe_t             stb,
  input  logic                    regWrEn,
  input  logic [REG_AW-1:0]       regAddr,
  input  logic [7:0]              regWrData,
  output logic [7:0]              regRdData,
  input  logic                    frmValid,
  input  logic [7:0]              frmData,
  input  logic [7:0]              frmStatus,
  output logic                    memWe,
  output logic [PAGE_W+OFF_W-1:0] memAddr,
  output logic [7:0]              memData,
  output logic                    frmStored,
  output logic                    frmMissed,
  output logic                    ovwFlag,
  output logic                    modeMonitor,
  output logic                    modeKeepBad,
  output logic                    curIsFence,
  output logic                    ptrIsFence
);
  localparam int CNT_W = 16;

  logic [PAGE_W-1:0] firstPage, limitPage, curPage, fencePage, startPage;
  logic [PAGE_W-1:0] ptrPage, nextPkt;
  logic [OFF_W-1:0]  ptrOff;
  logic [CNT_W-1:0]  byteCnt, hdrCount;
  logic [7:0]        hdrStatus, hdrByte;
  logic [PAGE_W-1:0] srcPage, advPage;
  logic [OFF_W-1:0]  srcOff, advOff;

  function automatic logic [PAGE_W-1:0] ringStep(input logic [PAGE_W-1:0] p,
                                                 input logic [PAGE_W-1:0] f,
                                                 input logic [PAGE_W-1:0] l);
    logic [PAGE_W-1:0] q;
    q = p + 1'b1;
    return (q == l) ? f : q;
  endfunction

  assign curIsFence = (curPage == fencePage);
  assign ptrIsFence = (ptrPage == fencePage);

  always_comb begin
    srcPage = stb.beginFrame ? curPage : ptrPage;
    srcOff  = stb.beginFrame ? OFF_W'(HDR_LEN) : ptrOff;
    advOff  = srcOff + 1'b1;
    advPage = (advOff == '0) ? ringStep(srcPage, firstPage, limitPage) : srcPage;
    nextPkt = (ptrOff == '0) ? ptrPage : ringStep(ptrPage, firstPage, limitPage);
    hdrCount = byteCnt + CNT_W'(HDR_LEN);
    unique case (stb.hdrIdx)
      2'd0:    hdrByte = hdrStatus;
      2'd1:    hdrByte = 8'(nextPkt);
      2'd2:    hdrByte = hdrCount[7:0];
      default: hdrByte = hdrCount[15:8];
    endcase
  end

  always_comb begin
    unique case (regAddr)
      ADDR_FIRST:  regRdData = 8'(firstPage);
      ADDR_LIMIT:  regRdData = 8'(limitPage);
      ADDR_WRPAGE: regRdData = 8'(curPage);
      ADDR_FENCE:  regRdData = 8'(fencePage);
      ADDR_MODE:   regRdData = {6'd0, modeMonitor, modeKeepBad};
      ADDR_STAT:   regRdData = {7'd0, ovwFlag};
      default:     regRdData = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      firstPage   <= RST_FIRST;
      limitPage   <= RST_LIMIT;
      curPage     <= RST_WRPAGE;
      fencePage   <= RST_FENCE;
      modeMonitor <= 1'b0;
      modeKeepBad <= 1'b0;
      ovwFlag     <= 1'b0;
    end else begin
      if (stb.commit) curPage <= nextPkt;
      if (stb.markOverrun)
        ovwFlag <= 1'b1;
      else if (regWrEn && regAddr == ADDR_FENCE && PAGE_W'(regWrData) != fencePage)
        ovwFlag <= 1'b0;
      if (regWrEn) begin
        unique case (regAddr)
          ADDR_FIRST:  firstPage <= PAGE_W'(regWrData);
          ADDR_LIMIT:  limitPage <= PAGE_W'(regWrData);
          ADDR_WRPAGE: curPage   <= PAGE_W'(regWrData);
          ADDR_FENCE:  fencePage <= PAGE_W'(regWrData);
          ADDR_MODE:   {modeMonitor, modeKeepBad} <= regWrData[1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      startPage <= '0;
      ptrPage   <= '0;
      ptrOff    <= '0;
      byteCnt   <= '0;
      hdrStatus <= '0;
      memWe     <= 1'b0;
      memAddr   <= '0;
      memData   <= '0;
      frmStored <= 1'b0;
      frmMissed <= 1'b0;
    end else begin
      if (stb.beginFrame) startPage <= curPage;
      if (stb.takeByte) begin
        ptrPage <= advPage;
        ptrOff  <= advOff;
        byteCnt <= stb.beginFrame ? CNT_W'(1) : byteCnt + 1'b1;
      end
      if (stb.endByte) hdrStatus <= frmStatus;
      memWe <= stb.doWrite || stb.hdrWrite;
      if (stb.hdrWrite) begin
        memAddr <= {startPage, OFF_W'(stb.hdrIdx)};
        memData <= hdrByte;
      end else begin
        memAddr <= {srcPage, srcOff};
        memData <= frmData;
      end
      frmStored <= stb.commit;
      frmMissed <= stb.markMissed;
    end
  end

  // R9
  fence_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    memWe |-> memAddr[PAGE_W+OFF_W-1:OFF_W] != fencePage);
  // R11
  ovw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovwFlag) |-> ($past(regWrEn) && $past(regAddr) == ADDR_FENCE
                        && $past(regWrData) != 8'($past(fencePage))));
  // R5
  stored_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frmStored |-> (memWe && memAddr[OFF_W-1:0] == OFF_W'(3)));
  // R3
  cur_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frmStored |-> (curPage >= firstPage && curPage < limitPage));
  // R8
  monitor_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frmValid && modeMonitor && !stb.hdrWrite) |=> !memWe);
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
  import rx_ring_pkg::*;
#(
  parameter int PAGE_W  = 8,
  parameter int OFF_W   = 8,
  parameter int HDR_LEN = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    regWrEn,
  input  logic [2:0]              regAddr,
  input  logic [7:0]              regWrData,
  output logic [7:0]              regRdData,
  input  logic                    frmValid,
  input  logic [7:0]              frmData,
  input  logic                    frmEnd,
  input  logic [7:0]              frmStatus,
  output logic                    memWe,
  output logic [PAGE_W+OFF_W-1:0] memAddr,
  output logic [7:0]              memData,
  output logic                    frmStored,
  output logic                    frmMissed,
  output logic                    ovwFlag
);
  ringStrobe_t stb;
  logic modeMonitor, modeKeepBad, curIsFence, ptrIsFence;

  rx_ring_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .frmValid(frmValid), .frmEnd(frmEnd), .frmGood(frmStatus[0]),
    .modeMonitor(modeMonitor), .modeKeepBad(modeKeepBad), .ovwSet(ovwFlag),
    .curIsFence(curIsFence), .ptrIsFence(ptrIsFence), .stb(stb)
  );

  rx_ring_dp #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .HDR_LEN(HDR_LEN)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .frmValid(frmValid), .frmData(frmData), .frmStatus(frmStatus),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .frmStored(frmStored), .frmMissed(frmMissed), .ovwFlag(ovwFlag),
    .modeMonitor(modeMonitor), .modeKeepBad(modeKeepBad),
    .curIsFence(curIsFence), .ptrIsFence(ptrIsFence)
  );

  // R6
  outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frmStored && frmMissed));
endmodule

// File: tb/rx_ring_mgr_tb.sv
module rx_ring_mgr_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic frmValid = 1'b0, frmEnd = 1'b0;
  logic [7:0] frmData = '0, frmStatus = '0;
  logic memWe, frmStored, frmMissed, ovwFlag;
  logic [15:0] memAddr;
  logic [7:0] memData;

  always #2 clk = ~clk;

  rx_ring_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .frmValid(frmValid),
    .frmData(frmData), .frmEnd(frmEnd), .frmStatus(frmStatus),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .frmStored(frmStored), .frmMissed(frmMissed), .ovwFlag(ovwFlag)
  );

  int errors = 0, checks = 0;
  int storedCnt = 0, missedCnt = 0, writeCnt = 0, fenceHits = 0;
  logic [7:0] watchPage = 8'hFF;
  logic [7:0] shadow [0:1023];

  always @(negedge clk) begin
    if (frmStored) storedCnt++;
    if (frmMissed) missedCnt++;
    if (memWe) begin
      writeCnt++;
      shadow[memAddr[9:0]] = memData;
      if (memAddr[15:8] == watchPage) fenceHits++;
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finishRun();
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic sendFrame(input int len, input logic [7:0] st, input logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      frmValid = 1'b1; frmData = seed + 8'(i); frmEnd = (i == len - 1); frmStatus = st;
    end
    @(negedge clk);
    frmValid = 1'b0; frmEnd = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  // ring for tests: pages 0x10..0x12
  function automatic int byteAddr(input int startPg, input int idx);
    int pg, lin;
    pg = startPg; lin = 4 + idx;
    while (lin >= 256) begin
      lin -= 256;
      pg = (pg + 1 == 8'h13) ? 8'h10 : pg + 1;
    end
    return pg * 256 + lin;
  endfunction

  // {len[47:32], status[31:24], mode[23:16], expWrPage[15:8], outcome[7:0]}
  // outcome: 0 kept, 1 missed, 2 dropped
  localparam logic [47:0] VEC [6] = '{
    {16'd10,  8'h01, 8'h00, 8'h11, 8'd0},   // R2 R4 R5 basic
    {16'd252, 8'h01, 8'h00, 8'h12, 8'd0},   // R5 exact page fill
    {16'd300, 8'h01, 8'h00, 8'h11, 8'd0},   // R3 wrap
    {16'd20,  8'h02, 8'h00, 8'h11, 8'd2},   // R6 dropped
    {16'd20,  8'h02, 8'h01, 8'h12, 8'd0},   // R7 kept bad
    {16'd20,  8'h01, 8'h02, 8'h12, 8'd1}    // R8 monitor
  };

  initial begin
    logic [7:0] rd;
    int sBase, mBase, wBase;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    regRead(3'd0, rd); check("R1 first", rd, 8'h40);
    regRead(3'd1, rd); check("R1 limit", rd, 8'h80);
    regRead(3'd2, rd); check("R1 wrpage", rd, 8'h41);
    regRead(3'd3, rd); check("R1 fence", rd, 8'h40);
    regRead(3'd4, rd); check("R1 mode", rd, 0);
    regRead(3'd5, rd); check("R1 status", rd, 0);
    check("R1 memWe", memWe, 0);

    regWrite(3'd0, 8'h10); regWrite(3'd1, 8'h13);
    regWrite(3'd2, 8'h10); regWrite(3'd3, 8'h0F);
    regRead(3'd1, rd); check("R12 limit readback", rd, 8'h13);
    regRead(3'd3, rd); check("R12 fence readback", rd, 8'h0F);

    for (int v = 0; v < 6; v++) begin
      int len, sp, out, cnt;
      logic [7:0] st, seed, expPg;
      len = int'(VEC[v][47:32]); st = VEC[v][31:24];
      expPg = VEC[v][15:8]; out = int'(VEC[v][7:0]);
      seed = 8'(v * 16 + 3);
      regWrite(3'd4, VEC[v][23:16]);
      regRead(3'd2, rd); sp = int'(rd);
      sBase = storedCnt; mBase = missedCnt; wBase = writeCnt;
      sendFrame(len, st, seed);
      regRead(3'd2, rd);
      check($sformatf("R5 vec%0d wrpage", v), rd, expPg);
      check($sformatf("R5 vec%0d stored pulse", v), storedCnt - sBase, out == 0);
      check($sformatf("R8 vec%0d missed pulse", v), missedCnt - mBase, out == 1);
      if (out == 0) begin
        cnt = len + 4;
        check($sformatf("R4 vec%0d status", v), shadow[(sp * 256) % 1024], st);
        check($sformatf("R4 vec%0d next", v), shadow[(sp * 256 + 1) % 1024], expPg);
        check($sformatf("R4 vec%0d cntlo", v), shadow[(sp * 256 + 2) % 1024], cnt & 255);
        check($sformatf("R4 vec%0d cnthi", v), shadow[(sp * 256 + 3) % 1024], cnt >> 8);
        check($sformatf("R2 vec%0d first", v), shadow[byteAddr(sp, 0) % 1024], seed);
        check($sformatf("R3 vec%0d last", v), shadow[byteAddr(sp, len - 1) % 1024],
              8'(seed + 8'(len - 1)));
        check($sformatf("R5 vec%0d writes", v), writeCnt - wBase, len + 4);
      end else if (out == 1) begin
        check($sformatf("R8 vec%0d no writes", v), writeCnt - wBase, 0);
      end else begin
        check($sformatf("R6 vec%0d no header", v), writeCnt - wBase, len);
      end
    end

    // R9 overrun mid-frame at a page crossing
    regWrite(3'd4, 8'h00); regWrite(3'd2, 8'h12); regWrite(3'd3, 8'h10);
    watchPage = 8'h10;
    sBase = storedCnt; mBase = missedCnt; wBase = writeCnt; fenceHits = 0;
    sendFrame(300, 8'h01, 8'h55);
    check("R9 fence page untouched", fenceHits, 0);
    check("R9 writes before fence", writeCnt - wBase, 252);
    check("R9 missed", missedCnt - mBase, 1);
    check("R9 not stored", storedCnt - sBase, 0);
    check("R9 ovwFlag", ovwFlag, 1);
    regRead(3'd5, rd); check("R9 status bit", rd, 1);
    regRead(3'd2, rd); check("R9 wrpage kept", rd, 8'h12);

    // R10 frames while flag set
    mBase = missedCnt; wBase = writeCnt;
    sendFrame(5, 8'h01, 8'h20);
    check("R10 missed", missedCnt - mBase, 1);
    check("R10 no writes", writeCnt - wBase, 0);

    // R11 same value keeps flag, new value clears
    regWrite(3'd3, 8'h10);
    check("R11 same fence keeps", ovwFlag, 1);
    regWrite(3'd3, 8'h11);
    check("R11 new fence clears", ovwFlag, 0);

    sBase = storedCnt;
    sendFrame(10, 8'h01, 8'h30);
    check("R3 stored after clear", storedCnt - sBase, 1);
    regRead(3'd2, rd); check("R3 wrpage wraps", rd, 8'h10);
    check("R4 next wraps", shadow[(8'h12 * 256 + 1) % 1024], 8'h10);

    // R9 overrun at frame start (write page equals fence)
    regWrite(3'd3, 8'h10);
    mBase = missedCnt; wBase = writeCnt;
    sendFrame(3, 8'h01, 8'h40);
    check("R9 start missed", missedCnt - mBase, 1);
    check("R9 start no writes", writeCnt - wBase, 0);
    check("R9 start flag", ovwFlag, 1);

    finishRun();
  end
endmodule